// File: doc/BRIEF.md
# Spurious Power Suppression Adder/Subtractor

This block is a 32-bit two's complement adder/subtractor whose datapath is cut into a 16-bit lower slice and a 16-bit upper slice. A detection unit inspects the upper halves of the two operands. When those halves carry no information beyond sign, it shuts the upper slice off. The upper adder then receives zeros through AND gates, so its inputs stop toggling. The upper result bits come from a small sign-extension unit instead of the upper adder.

The block is purely combinational. The caller drives two operands and an add/subtract select and reads the 32-bit result. The caller can also observe the three detection controls: shut-off, carry control and replicated sign. The gated upper-slice operands are exposed as well, so that the effect of the gating can be observed directly. In every case the result equals a plain 32-bit add or subtract.

Top module: `spst_adder`

## Requirements
- R1: With `sub_en` = 0, `result` equals (`op_a` + `op_b`) mod 2^32.
- R2: With `sub_en` = 1, `result` equals (`op_a` − `op_b`) mod 2^32. The block forms this as `op_a` + ~`op_b` + 1. The effective B operand is `op_b` when adding and ~`op_b` when subtracting.
- R3: `close_o` is 1 exactly when `op_a[31:16]` is all zeros or all ones and the effective B bits [31:16] are also all zeros or all ones.
- R4: While `close_o` is 1, `gated_hi_a` and `gated_hi_b` are both zero, whatever the operand values.
- R5: While `close_o` is 0, `gated_hi_a` equals `op_a[31:16]` and `gated_hi_b` equals the effective B bits [31:16].
- R6: While `close_o` is 1, `sign_o` equals `result[31]` and bits 31 down to 17 of `result` all equal `sign_o`. While `close_o` is 0, `sign_o` is 0.
- R7: Let the lower carry be bit 16 of `op_a[15:0]` + effective B[15:0] + `sub_en`. While `close_o` is 0, `carry_ctrl_o` equals this lower carry. While `close_o` is 1, `carry_ctrl_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand, two's complement |
| op_b | input | 32 | Second operand, two's complement |
| sub_en | input | 1 | 0 selects add, 1 selects subtract (a − b) |
| result | output | 32 | Sum or difference, mod 2^32 |
| close_o | output | 1 | Upper slice switched off |
| carry_ctrl_o | output | 1 | Lower carry passed into the upper adder |
| sign_o | output | 1 | Value replicated across the upper result bits while switched off |
| gated_hi_a | output | 16 | Upper-slice A input after the AND gates |
| gated_hi_b | output | 16 | Upper-slice effective B input after the AND gates |

## Verification
On every input change, the assertions check these properties:
- the result matches a reference add or subtract;
- the gated operands are zero while the upper slice is off, and are the true upper halves while it is on;
- the shut-off decision follows the uniform-halves rule;
- the replicated sign and the carry control are consistent with the result.

The bench scenarios target the cases that random inputs seldom reach:
- a carry out of the lower slice into an otherwise empty upper half;
- two all-ones upper halves;
- mixed-sign small operands;
- small subtractions where inverting B flips the uniform upper half.

Only these scenarios show that suppression actually occurs for small operands while wide operands keep the upper adder running.

// File: rtl/spst_pkg.sv
package spst_pkg;
  parameter int unsigned DATA_W  = 32;
  parameter int unsigned SPLIT_W = 16;

  typedef struct packed {
    logic close;
    logic carry_ctrl;
    logic sign;
  } spst_ctrl_t;
endpackage

// File: rtl/spst_operand_prep.sv
module spst_operand_prep #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] b_in,
  input  logic         sub_en,
  output logic [W-1:0] b_eff,
  output logic         cin
);
  // Subtraction becomes addition of the one's complement with a carry-in of 1.
  always_comb begin
    b_eff = b_in ^ {W{sub_en}};
    cin   = sub_en;
  end
endmodule

// File: rtl/spst_detect.sv
module spst_detect #(
  parameter int unsigned HW = 16
) (
  input  logic [HW-1:0]         hi_a,
  input  logic [HW-1:0]         hi_b,
  input  logic                  lo_cout,
  output spst_pkg::spst_ctrl_t  ctrl
);
  logic a_flat, b_flat, a_msb, b_msb;

  always_comb begin
    a_flat = (&hi_a) | ~(|hi_a);
    b_flat = (&hi_b) | ~(|hi_b);
    a_msb  = hi_a[HW-1];
    b_msb  = hi_b[HW-1];
    ctrl.close      = a_flat & b_flat;
    // Carry only travels upward while the upper adder is live.
    ctrl.carry_ctrl = ~ctrl.close & lo_cout;
    // Both all-ones: negative. Mixed: negative unless the lower carry wraps it.
    ctrl.sign       = ctrl.close & ((a_msb & b_msb) | ((a_msb ^ b_msb) & ~lo_cout));
  end
endmodule

// File: rtl/spst_and_latch.sv
module spst_and_latch #(
  parameter int unsigned HW = 16
) (
  input  logic [HW-1:0] hi_a,
  input  logic [HW-1:0] hi_b,
  input  logic          close,
  output logic [HW-1:0] g_a,
  output logic [HW-1:0] g_b
);
  for (genvar i = 0; i < HW; i++) begin : g_bit
    assign g_a[i] = hi_a[i] & ~close;
    assign g_b[i] = hi_b[i] & ~close;
  end
endmodule

// File: rtl/spst_sign_ext.sv
module spst_sign_ext #(
  parameter int unsigned HW = 16
) (
  input  logic          a_lsb,
  input  logic          b_lsb,
  input  logic          lo_cout,
  input  logic          sign,
  output logic [HW-1:0] hi_out
);
  // Bit 16 still sees the lower carry; everything above it is pure sign.
  always_comb begin
    hi_out = {{(HW-1){sign}}, a_lsb ^ b_lsb ^ lo_cout};
  end
endmodule

// File: rtl/spst_adder.sv
module spst_adder #(
  parameter int unsigned W     = spst_pkg::DATA_W,
  parameter int unsigned SPLIT = spst_pkg::SPLIT_W
) (
  input  logic [W-1:0]       op_a,
  input  logic [W-1:0]       op_b,
  input  logic               sub_en,
  output logic [W-1:0]       result,
  output logic               close_o,
  output logic               carry_ctrl_o,
  output logic               sign_o,
  output logic [W-SPLIT-1:0] gated_hi_a,
  output logic [W-SPLIT-1:0] gated_hi_b
);
  localparam int unsigned HW = W - SPLIT;

  logic [W-1:0]       b_eff;
  logic               cin;
  logic [SPLIT:0]     lo_full;
  logic [HW-1:0]      hi_sum;
  logic [HW-1:0]      hi_ext;
  spst_pkg::spst_ctrl_t ctrl;

  spst_operand_prep #(.W(W)) u_prep (
    .b_in  (op_b),
    .sub_en(sub_en),
    .b_eff (b_eff),
    .cin   (cin)
  );

  always_comb begin
    lo_full = {1'b0, op_a[SPLIT-1:0]} + {1'b0, b_eff[SPLIT-1:0]} + {{SPLIT{1'b0}}, cin};
  end

  spst_detect #(.HW(HW)) u_detect (
    .hi_a   (op_a[W-1:SPLIT]),
    .hi_b   (b_eff[W-1:SPLIT]),
    .lo_cout(lo_full[SPLIT]),
    .ctrl   (ctrl)
  );

  spst_and_latch #(.HW(HW)) u_gate (
    .hi_a (op_a[W-1:SPLIT]),
    .hi_b (b_eff[W-1:SPLIT]),
    .close(ctrl.close),
    .g_a  (gated_hi_a),
    .g_b  (gated_hi_b)
  );

  always_comb begin
    hi_sum = gated_hi_a + gated_hi_b + {{(HW-1){1'b0}}, ctrl.carry_ctrl};
  end

  spst_sign_ext #(.HW(HW)) u_ext (
    .a_lsb  (op_a[SPLIT]),
    .b_lsb  (b_eff[SPLIT]),
    .lo_cout(lo_full[SPLIT]),
    .sign   (ctrl.sign),
    .hi_out (hi_ext)
  );

  always_comb begin
    result       = {(ctrl.close ? hi_ext : hi_sum), lo_full[SPLIT-1:0]};
    close_o      = ctrl.close;
    carry_ctrl_o = ctrl.carry_ctrl;
    sign_o       = ctrl.sign;
  end
endmodule

// File: rtl/spst_adder_chk.sv
module spst_adder_chk #(
  parameter int unsigned W     = 32,
  parameter int unsigned SPLIT = 16
) (
  input logic [W-1:0]       op_a,
  input logic [W-1:0]       op_b,
  input logic               sub_en,
  input logic [W-1:0]       result,
  input logic               close_o,
  input logic               carry_ctrl_o,
  input logic               sign_o,
  input logic [W-SPLIT-1:0] gated_hi_a,
  input logic [W-SPLIT-1:0] gated_hi_b
);
  localparam int unsigned HW = W - SPLIT;

  logic [W-1:0]  ref_sum;
  logic [W-1:0]  ref_b;
  logic [HW-1:0] ref_a_hi, ref_b_hi;
  logic [SPLIT:0] ref_lo;

  always_comb begin
    ref_sum  = sub_en ? (op_a - op_b) : (op_a + op_b);
    ref_b    = sub_en ? ~op_b : op_b;
    ref_a_hi = op_a[W-1:SPLIT];
    ref_b_hi = ref_b[W-1:SPLIT];
    ref_lo   = {1'b0, op_a[SPLIT-1:0]} + {1'b0, ref_b[SPLIT-1:0]} + {{SPLIT{1'b0}}, sub_en};
  end

  always_comb begin
    if (!$isunknown({op_a, op_b, sub_en})) begin
      AST_RESULT_ADD: assert (sub_en || result == ref_sum); // R1
      AST_RESULT_SUB: assert (!sub_en || result == ref_sum); // R2
      AST_CLOSE_RULE: assert (close_o == (((&ref_a_hi) || !(|ref_a_hi)) && ((&ref_b_hi) || !(|ref_b_hi)))); // R3
      AST_GATE_ZERO: assert (!close_o || (gated_hi_a == '0 && gated_hi_b == '0)); // R4
      AST_GATE_PASS: assert (close_o || (gated_hi_a == ref_a_hi && gated_hi_b == ref_b_hi)); // R5
      AST_SIGN_REPL: assert (close_o ? (sign_o == result[W-1] && (result[W-1:SPLIT+1] == {(HW-1){sign_o}})) : !sign_o); // R6
      AST_CARRY_CTRL: assert (carry_ctrl_o == (!close_o && ref_lo[SPLIT])); // R7
    end
  end
endmodule

bind spst_adder spst_adder_chk #(.W(W), .SPLIT(SPLIT)) u_chk (.*);

// File: tb/spst_adder_test.sv
module spst_adder_test;
  logic        clk;
  logic        rst_n;
  logic [31:0] op_a, op_b;
  logic        sub_en;
  logic [31:0] result;
  logic        close_o, carry_ctrl_o, sign_o;
  logic [15:0] gated_hi_a, gated_hi_b;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  spst_adder uut (
    .op_a(op_a), .op_b(op_b), .sub_en(sub_en), .result(result),
    .close_o(close_o), .carry_ctrl_o(carry_ctrl_o), .sign_o(sign_o),
    .gated_hi_a(gated_hi_a), .gated_hi_b(gated_hi_b)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic expect_val(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // Drives one vector and checks every output against the requirements.
  task automatic run_vec(logic [31:0] a, logic [31:0] b, logic s);
    logic [31:0] eb, exp_res;
    logic [16:0] lo;
    logic        exp_close, a_flat, b_flat;
    @(negedge clk);
    op_a = a; op_b = b; sub_en = s;
    @(posedge clk); #2;
    eb      = s ? ~b : b;
    exp_res = s ? a - b : a + b;
    lo      = {1'b0, a[15:0]} + {1'b0, eb[15:0]} + {16'd0, s};
    a_flat  = (a[31:16] == 16'h0000) || (a[31:16] == 16'hFFFF);
    b_flat  = (eb[31:16] == 16'h0000) || (eb[31:16] == 16'hFFFF);
    exp_close = a_flat && b_flat;
    if (s) expect_val("R2", "result", result, exp_res);
    else   expect_val("R1", "result", result, exp_res);
    expect_val("R3", "close", {31'd0, close_o}, {31'd0, exp_close});
    if (exp_close) begin
      expect_val("R4", "gated_a", {16'd0, gated_hi_a}, 32'd0);
      expect_val("R4", "gated_b", {16'd0, gated_hi_b}, 32'd0);
      expect_val("R6", "sign", {31'd0, sign_o}, {31'd0, exp_res[31]});
      expect_val("R7", "carry_ctrl", {31'd0, carry_ctrl_o}, 32'd0);
    end else begin
      expect_val("R5", "gated_a", {16'd0, gated_hi_a}, {16'd0, a[31:16]});
      expect_val("R5", "gated_b", {16'd0, gated_hi_b}, {16'd0, eb[31:16]});
      expect_val("R6", "sign", {31'd0, sign_o}, 32'd0);
      expect_val("R7", "carry_ctrl", {31'd0, carry_ctrl_o}, {31'd0, lo[16]});
    end
  endtask

  task automatic t_reset_state;
    // Idle operands of zero: upper slice off, everything low.
    expect_val("R1", "idle result", result, 32'd0);
    expect_val("R3", "idle close", {31'd0, close_o}, 32'd1);
    expect_val("R6", "idle sign", {31'd0, sign_o}, 32'd0);
    expect_val("R7", "idle carry_ctrl", {31'd0, carry_ctrl_o}, 32'd0);
  endtask

  task automatic t_small_positive;
    run_vec(32'd5, 32'd7, 1'b0);
    run_vec(32'd1000, 32'd24000, 1'b0);
    expect_val("R1", "small add", result, 32'd25000);
  endtask

  task automatic t_small_negative;
    run_vec(32'hFFFF_FFFD, 32'hFFFF_FFF0, 1'b0); // -3 + -16
    expect_val("R6", "neg sum", result, 32'hFFFF_FFED);
    run_vec(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    expect_val("R6", "all ones", result, 32'hFFFF_FFFE);
  endtask

  task automatic t_mixed_sign;
    run_vec(32'hFFFF_FFF6, 32'd4, 1'b0);  // -10 + 4 stays negative
    run_vec(32'hFFFF_FFFC, 32'd10, 1'b0); // -4 + 10 wraps positive
    expect_val("R1", "mixed wrap", result, 32'd6);
  endtask

  task automatic t_low_carry_boundary;
    run_vec(32'h0000_FFFF, 32'd1, 1'b0);  // carry into empty upper half
    expect_val("R1", "carry into bit16", result, 32'h0001_0000);
    run_vec(32'h0000_8000, 32'h0000_8000, 1'b0);
  endtask

  task automatic t_subtract;
    run_vec(32'd3, 32'd9, 1'b1);
    expect_val("R2", "3-9", result, 32'hFFFF_FFFA);
    run_vec(32'd9, 32'd3, 1'b1);
    run_vec(32'hFFFF_FFF0, 32'hFFFF_FFFE, 1'b1);
    run_vec(32'h0000_0000, 32'h0000_0000, 1'b1);
  endtask

  task automatic t_wide_operands;
    run_vec(32'h1234_5678, 32'h0FED_CBA9, 1'b0);
    run_vec(32'h7FFF_FFFF, 32'd1, 1'b0);
    run_vec(32'h8000_0000, 32'd1, 1'b1);
    run_vec(32'h0001_0000, 32'h0000_0001, 1'b0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      a = $urandom();
      b = $urandom();
      if (i % 3 == 0) a = {{16{a[15]}}, a[15:0]};
      if (i % 4 == 0) b = {{16{b[15]}}, b[15:0]};
      run_vec(a, b, i[0]);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    op_a = '0; op_b = '0; sub_en = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_small_positive();
    t_small_negative();
    t_mixed_sign();
    t_low_carry_boundary();
    t_subtract();
    t_wide_operands();
    t_random();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule